// File: doc/BRIEF.md
# Interrupt Sampling and Arbitration Unit

This block sits beside the instruction sequencer of an 8-bit processor. It watches the two interrupt pins and tells the sequencer whether to start a hardware interrupt sequence at the next instruction boundary.

The non-maskable pin is active low and edge sensitive. A falling transition is captured and held until it is consumed. The maskable pin is active low and level sensitive, and it is never latched. Each detector keeps a current view and a view delayed by one cycle. Polling always uses the delayed view.

The sequencer drives three strobes:
- A poll strobe loads the take decisions.
- An optional second poll in the same instruction can only add requests.
- A boundary strobe consumes the decisions.

The block also drives a registered vector address and the value of the break bit that belongs in the pushed status byte. During a software break, the sequencer pulses a strobe just before the vector fetch. A non-maskable edge that is present at that moment redirects the fetch to the non-maskable vector.

Top module: `irq_arbiter_top`

## Requirements
- R1: A high-to-low transition of `nmi_n_i`, seen between two clock edges, captures an edge. The delayed view of that edge is set one cycle later. The captured edge remains held whatever the pin does afterwards, until it is cleared by R7 or R8.
- R2: A low level on `irq_n_i` is seen in the delayed view two clock edges later. Once the pin returns high, the request disappears after the same delay, because nothing is latched.
- R3: A `poll_i` strobe overwrites both decisions. The take-NMI decision becomes the delayed edge. The take-IRQ decision becomes the delayed level ANDed with `i_flag_i` being low. The outputs change after the clock edge that samples the strobe.
- R4: `i_flag_i` has no effect on the take-NMI decision.
- R5: A `repoll_i` strobe ORs fresh results into the held decisions and never clears a decision that is already set.
- R6: `take_irq_o` is never high while `take_nmi_o` is high. When both requests are pending, the non-maskable one is presented first.
- R7: A `boundary_i` strobe does the following:
  - It clears both decisions.
  - If `take_nmi_o` was high, it clears the captured edge and sets `vec_addr_o` to 0xFFFA.
  - Otherwise it sets `vec_addr_o` to 0xFFFE.
  - It sets `brk_bit_o` to 0 when a hardware interrupt was taken, and to 1 otherwise.
- R8: A `brk_vec_i` strobe while the current (undelayed) edge is held sets `vec_addr_o` to 0xFFFA and clears the edge. Without a held edge, the strobe has no effect.
- R9: After reset, both detectors are clear, both take outputs are 0, `vec_addr_o` is 0xFFFC and `brk_bit_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_n_i | input | 1 | Non-maskable interrupt pin, active low, edge sensitive |
| irq_n_i | input | 1 | Maskable interrupt pin, active low, level sensitive |
| i_flag_i | input | 1 | Interrupt-disable flag from the status register |
| poll_i | input | 1 | First poll of the instruction; overwrites the decisions |
| repoll_i | input | 1 | Second poll; ORs into the decisions |
| boundary_i | input | 1 | Instruction boundary; consumes the decisions |
| brk_vec_i | input | 1 | Software break is about to fetch its vector |
| take_nmi_o | output | 1 | Start the non-maskable sequence at the boundary |
| take_irq_o | output | 1 | Start the maskable sequence at the boundary |
| vec_addr_o | output | ADDR_W | Address of the vector low byte |
| brk_bit_o | output | 1 | Break bit value for the pushed status byte |

## Verification
Some properties are checked on every cycle:
- The two take outputs are mutually exclusive.
- A masked poll never yields an IRQ take.
- A second poll never drops a decision.
- Entering the non-maskable sequence empties the delayed edge.
- A break redirect always leaves the non-maskable vector selected.

Other behaviour can only be shown by the directed scenarios:
- The exact latency from a pin change to a visible decision.
- That an edge survives the pin returning high.
- That a consumed edge does not reappear while the pin stays low.
- That the maskable level is forgotten once the pin rises.
- The vector and break-bit values after each kind of boundary.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // low three bits of the vector address; upper bits are all ones
  typedef enum logic [2:0] {
    VK_NMI   = 3'b010,
    VK_RESET = 3'b100,
    VK_IRQ   = 3'b110
  } vec_kind_e;
endpackage

// File: rtl/nmi_edge_det.sv
module nmi_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_n_i,
  input  logic clr_i,
  output logic cur_o,
  output logic dly_o
);
  logic pin_q;
  logic fall;

  assign fall = pin_q & ~pin_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b1;
      cur_o <= 1'b0;
      dly_o <= 1'b0;
    end else begin
      pin_q <= pin_n_i;
      if (fall)       cur_o <= 1'b1;
      else if (clr_i) cur_o <= 1'b0;
      dly_o <= clr_i ? 1'b0 : cur_o;
    end
  end

  // R1: a held edge only goes away through a clear
  a_r1_edge_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_o && !clr_i) |=> cur_o);
endmodule

// File: rtl/irq_level_det.sv
module irq_level_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_n_i,
  output logic cur_o,
  output logic dly_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_o <= 1'b0;
      dly_o <= 1'b0;
    end else begin
      cur_o <= ~pin_n_i;
      dly_o <= cur_o;
    end
  end
endmodule

// File: rtl/int_decider.sv
module int_decider (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic poll_i,
  input  logic repoll_i,
  input  logic boundary_i,
  input  logic i_flag_i,
  input  logic nmi_dly_i,
  input  logic irq_dly_i,
  output logic take_nmi_o,
  output logic take_irq_o,
  output logic nmi_entry_o
);
  logic nmi_q, irq_q;
  logic irq_req;

  assign irq_req = irq_dly_i & ~i_flag_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (boundary_i) begin
      nmi_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (poll_i) begin
      nmi_q <= nmi_dly_i;
      irq_q <= irq_req;
    end else if (repoll_i) begin
      nmi_q <= nmi_q | nmi_dly_i;
      irq_q <= irq_q | irq_req;
    end
  end

  assign take_nmi_o  = nmi_q;
  assign take_irq_o  = irq_q & ~nmi_q;
  assign nmi_entry_o = boundary_i & nmi_q;

  a_r3_masked_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_i && i_flag_i && !boundary_i) |=> !irq_q);
  a_r5_repoll_add_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (repoll_i && !poll_i && !boundary_i && (nmi_q || irq_q))
      |=> ($past(nmi_q) -> nmi_q) && ($past(irq_q) -> irq_q));
  a_r6_nmi_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(take_nmi_o && take_irq_o));
endmodule

// File: rtl/irq_arbiter_top.sv
module irq_arbiter_top #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nmi_n_i,
  input  logic              irq_n_i,
  input  logic              i_flag_i,
  input  logic              poll_i,
  input  logic              repoll_i,
  input  logic              boundary_i,
  input  logic              brk_vec_i,
  output logic              take_nmi_o,
  output logic              take_irq_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              brk_bit_o
);
  import irq_arb_pkg::*;

  localparam int HI_W = ADDR_W - 3;

  logic edge_cur, edge_dly, lvl_cur, lvl_dly;
  logic nmi_entry, brk_redirect, edge_clr;
  vec_kind_e vk_q;
  logic hw_q;

  assign brk_redirect = brk_vec_i & edge_cur;
  assign edge_clr     = nmi_entry | brk_redirect;

  nmi_edge_det u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_n_i(nmi_n_i), .clr_i(edge_clr),
    .cur_o(edge_cur), .dly_o(edge_dly)
  );

  irq_level_det u_level (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_n_i(irq_n_i),
    .cur_o(lvl_cur), .dly_o(lvl_dly)
  );

  int_decider u_decide (
    .clk_i(clk_i), .rst_ni(rst_ni), .poll_i(poll_i), .repoll_i(repoll_i),
    .boundary_i(boundary_i), .i_flag_i(i_flag_i), .nmi_dly_i(edge_dly),
    .irq_dly_i(lvl_dly), .take_nmi_o(take_nmi_o), .take_irq_o(take_irq_o),
    .nmi_entry_o(nmi_entry)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vk_q <= VK_RESET;
      hw_q <= 1'b0;
    end else if (boundary_i) begin
      vk_q <= take_nmi_o ? VK_NMI : VK_IRQ;
      hw_q <= take_nmi_o | take_irq_o;
    end else if (brk_redirect) begin
      vk_q <= VK_NMI;
    end
  end

  assign vec_addr_o = {{HI_W{1'b1}}, vk_q};
  assign brk_bit_o  = ~hw_q;

  a_r7_entry_clears_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && take_nmi_o) |=> !edge_dly);
  a_r8_brk_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_vec_i && !boundary_i && edge_cur) |=> (vec_addr_o[2:0] == 3'b010) && !edge_dly);
  a_r9_lvl_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lvl_cur |=> !lvl_dly);
endmodule

// File: tb/irq_arbiter_top_tb.sv
`timescale 1ns/1ps
module irq_arbiter_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_n = 1'b1, irq_n = 1'b1, i_flag = 1'b0;
  logic poll = 1'b0, repoll = 1'b0, boundary = 1'b0, brk_vec = 1'b0;
  logic take_nmi, take_irq, brk_bit;
  logic [15:0] vec;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_arbiter_top #(.ADDR_W(16)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .nmi_n_i(nmi_n), .irq_n_i(irq_n),
    .i_flag_i(i_flag), .poll_i(poll), .repoll_i(repoll),
    .boundary_i(boundary), .brk_vec_i(brk_vec), .take_nmi_o(take_nmi),
    .take_irq_o(take_irq), .vec_addr_o(vec), .brk_bit_o(brk_bit)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_poll();   poll = 1'b1;     tick(); poll = 1'b0;     endtask
  task automatic pulse_repoll(); repoll = 1'b1;   tick(); repoll = 1'b0;   endtask
  task automatic pulse_bound();  boundary = 1'b1; tick(); boundary = 1'b0; endtask

  task automatic t_reset();
    chk("R9 take_nmi", {15'd0, take_nmi}, 16'd0);
    chk("R9 take_irq", {15'd0, take_irq}, 16'd0);
    chk("R9 vec", vec, 16'hFFFC);
    chk("R9 brk_bit", {15'd0, brk_bit}, 16'd1);
    pulse_poll();
    chk("R9 detectors clear", {14'd0, take_nmi, take_irq}, 16'd0);
  endtask

  task automatic t_nmi_basic();
    nmi_n = 1'b0; tick();
    pulse_poll();
    chk("R1 delayed view not yet set", {15'd0, take_nmi}, 16'd0);
    nmi_n = 1'b1;
    pulse_poll();
    chk("R1 edge held after pin rises", {15'd0, take_nmi}, 16'd1);
    pulse_bound();
    chk("R7 take cleared", {15'd0, take_nmi}, 16'd0);
    chk("R7 vec nmi", vec, 16'hFFFA);
    chk("R7 brk_bit hw", {15'd0, brk_bit}, 16'd0);
    nmi_n = 1'b0; tick(3);
    pulse_bound();
    pulse_poll();
    chk("R1 fresh edge while pin low", {15'd0, take_nmi}, 16'd1);
    pulse_bound();
    tick(2);
    pulse_poll();
    chk("R7 edge consumed, pin still low", {15'd0, take_nmi}, 16'd0);
    nmi_n = 1'b1; tick();
  endtask

  task automatic t_irq_level();
    irq_n = 1'b0; i_flag = 1'b1; tick(2);
    pulse_poll();
    chk("R3 masked irq", {15'd0, take_irq}, 16'd0);
    i_flag = 1'b0;
    pulse_poll();
    chk("R3 unmasked irq", {15'd0, take_irq}, 16'd1);
    pulse_bound();
    chk("R7 vec irq", vec, 16'hFFFE);
    chk("R7 brk_bit irq", {15'd0, brk_bit}, 16'd0);
    irq_n = 1'b1; tick(2);
    pulse_poll();
    chk("R2 level not latched", {15'd0, take_irq}, 16'd0);
  endtask

  task automatic t_nmi_unmasked();
    i_flag = 1'b1; nmi_n = 1'b0; tick(2);
    pulse_poll();
    chk("R4 nmi ignores i_flag", {15'd0, take_nmi}, 16'd1);
    pulse_bound(); nmi_n = 1'b1; i_flag = 1'b0; tick();
  endtask

  task automatic t_repoll();
    pulse_poll();
    chk("R5 nothing pending", {14'd0, take_nmi, take_irq}, 16'd0);
    irq_n = 1'b0; tick(2);
    pulse_repoll();
    chk("R5 repoll adds irq", {15'd0, take_irq}, 16'd1);
    irq_n = 1'b1; tick(2);
    pulse_repoll();
    chk("R5 repoll keeps irq", {15'd0, take_irq}, 16'd1);
    pulse_poll();
    chk("R3 poll overwrites", {15'd0, take_irq}, 16'd0);
  endtask

  task automatic t_priority();
    irq_n = 1'b0; nmi_n = 1'b0; tick(2);
    pulse_poll();
    chk("R6 both pending", {14'd0, take_nmi, take_irq}, 16'b10);
    pulse_bound();
    chk("R6 nmi vector first", vec, 16'hFFFA);
    pulse_poll();
    chk("R6 irq after nmi", {14'd0, take_nmi, take_irq}, 16'b01);
    pulse_bound();
    irq_n = 1'b1; nmi_n = 1'b1; tick(2);
  endtask

  task automatic t_brk();
    pulse_bound();
    chk("R7 sw boundary vec", vec, 16'hFFFE);
    chk("R7 sw boundary brk_bit", {15'd0, brk_bit}, 16'd1);
    brk_vec = 1'b1; tick(); brk_vec = 1'b0;
    chk("R8 no edge no change", vec, 16'hFFFE);
    nmi_n = 1'b0; tick();
    brk_vec = 1'b1; tick(); brk_vec = 1'b0;
    chk("R8 redirect vec", vec, 16'hFFFA);
    chk("R8 brk_bit kept", {15'd0, brk_bit}, 16'd1);
    tick(2);
    pulse_poll();
    chk("R8 edge cleared", {15'd0, take_nmi}, 16'd0);
    nmi_n = 1'b1; tick();
  endtask

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_nmi_basic();
    t_irq_level();
    t_nmi_unmasked();
    t_repoll();
    t_priority();
    t_brk();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule